// File: doc/BRIEF.md
# SPI Pause Gate

This block sits between the pins of a serial peripheral port and the shift engine of an SPI slave. It lets the host suspend a transfer part-way through with an active-low pause pin and then continue from the same bit. All four input pins are brought into the system clock through synchronizer chains. The block gives the slave qualified single-cycle strobes for rising and falling serial-clock edges, the synchronized data bit, and a level showing that a pause is active. The slave keeps its own shift state; because no strobe reaches it during a pause, that state is kept frozen.

A pause can begin or end only while the serial clock is low. If the pause pin changes while the clock is high, the change waits for the next falling clock edge. The serial-output enable does not wait for this. It is gated combinationally by the raw pause pin and chip select, so the output floats the moment the pause pin drops and drives again the moment it rises. Raising chip select ends the frame and clears any pause.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is asserted, and after it, `paused` is 0, no edge strobe is issued, and with the chip select high `so_oe` is 0.
- R2: When the pause pin goes low while the serial clock is low and chip select is low, `paused` becomes 1 within SYNC_STAGES+1 system clocks.
- R3: When the pause pin goes low while the serial clock is high, `paused` stays 0 until the clock next falls. That falling edge is still delivered as one `sck_fall_en` strobe, and `paused` becomes 1 after it.
- R4: When the pause pin goes high while the serial clock is low, `paused` returns to 0 within SYNC_STAGES+1 system clocks.
- R5: When the pause pin goes high while the serial clock is high, `paused` stays 1 until the clock next falls. No strobe is issued for that falling edge.
- R6: While `paused` is 1, serial-clock transitions produce no `sck_rise_en` or `sck_fall_en` strobes and data-pin changes are never sampled. After the pause ends, the next rising clock edge is delivered.
- R7: `so_oe` equals `so_oe_req` AND the pause pin (high = run) AND NOT chip select, with no clock edge in between.
- R8: Chip select high clears `paused` and suppresses all edge strobes, even when the pause pin is low.
- R9: Each rising serial-clock edge while selected and not paused gives exactly one `sck_rise_en` strobe. In that strobe cycle `si_data` carries the data-pin level that was set up before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| so_oe_req | input | 1 | Output-enable request from the slave shift engine |
| sck_rise_en | output | 1 | One-cycle strobe for a qualified rising serial-clock edge |
| sck_fall_en | output | 1 | One-cycle strobe for a qualified falling serial-clock edge |
| si_data | output | 1 | Synchronized data bit, aligned with the strobes |
| paused | output | 1 | Pause in effect |
| so_oe | output | 1 | Gated serial-output enable |

## Verification
The properties assume that every pin holds its level for at least SYNC_STAGES+1 system clocks between changes, so that each pin transition reaches the synchronized domain as one clean step. The stimulus keeps to this: it changes pins only on the falling system clock edge and waits four clocks after each change before it samples results or changes another pin. The single exception is the immediate output-enable check. There the pause pin is toggled and `so_oe` is read after a short delay with no clock edge in between, because that path is purely combinational.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  input  logic hold_n_pin,
  input  logic so_oe_req,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic si_data,
  output logic paused,
  output logic so_oe
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] IDLE_LEVELS = 4'b1010;

  logic [PINS-1:0] sync_q [SYNC_STAGES];
  logic cs_s, sck_s, hold_s, si_s, sck_d;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= IDLE_LEVELS;
          else        sync_q[0] <= {cs_n_pin, sck_pin, hold_n_pin, si_pin};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= IDLE_LEVELS;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign {cs_s, sck_s, hold_s, si_s} = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sck_d <= 1'b0;
    else             sck_d <= sck_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      paused <= 1'b0;
    else if (cs_s)   paused <= 1'b0;
    else if (!sck_s) paused <= !hold_s;

  wire live = !cs_s && !paused;

  assign sck_rise_en = live &&  sck_s && !sck_d;
  assign sck_fall_en = live && !sck_s &&  sck_d;
  assign si_data     = si_s;
  assign so_oe       = so_oe_req && hold_n_pin && !cs_n_pin;
endmodule

module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sck_s,
  input logic hold_s,
  input logic hold_n_pin,
  input logic paused,
  input logic so_oe,
  input logic sck_rise_en,
  input logic sck_fall_en
);
  // R8
  cs_clears_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !paused);

  // R2
  enter_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_s));

  // R5
  exit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> ($past(hold_s) || $past(cs_s)));

  // R6
  no_strobe_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !(sck_rise_en || sck_fall_en));

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_rise_en, sck_fall_en}));

  // R7
  always_comb if (rst_n && !hold_n_pin) so_oe_float_chk: assert (!so_oe);
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
  .hold_n_pin(hold_n_pin), .paused(paused), .so_oe(so_oe),
  .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en)
);

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, si = 0, hold_n = 1, oe_req = 0;
  logic rise_en, fall_en, si_data, paused, so_oe;
  int checks = 0, fails = 0, rises = 0, falls = 0;
  logic last_si = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_hold_gate uut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
    .hold_n_pin(hold_n), .so_oe_req(oe_req), .sck_rise_en(rise_en),
    .sck_fall_en(fall_en), .si_data(si_data), .paused(paused), .so_oe(so_oe)
  );

  always @(posedge clk) begin
    if (rise_en) begin rises <= rises + 1; last_si <= si_data; end
    if (fall_en) falls <= falls + 1;
  end

  // {cs_n, sck, hold_n, oe_req, exp_paused, exp_so_oe, exp_rise, exp_fall}
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV] = '{
    8'b1011_0000, 8'b0011_0100, 8'b0111_0110, 8'b0101_0000,
    8'b0001_1001, 8'b0101_1000, 8'b0111_1100, 8'b0011_0100,
    8'b0001_1000, 8'b0011_0100, 8'b0001_1000, 8'b1001_0000,
    8'b0010_0000
  };
  localparam string TAG [NV] = '{
    "R8", "R7", "R9", "R3", "R3", "R6", "R5", "R5",
    "R2", "R4", "R2", "R8", "R7"
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    int r0, f0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 paused in reset", paused, 0);
    check("R1 so_oe in reset", so_oe, 0);
    rst_n = 1;
    settle();
    check("R1 paused after reset", paused, 0);
    check("R1 no strobes after reset", rises + falls, 0);

    for (int i = 0; i < NV; i++) begin
      r0 = rises; f0 = falls;
      {cs_n, sck, hold_n, oe_req} = VEC[i][7:4];
      settle();
      check({TAG[i], " paused"}, paused, VEC[i][3]);
      check({TAG[i], " so_oe"}, so_oe, VEC[i][2]);
      check({TAG[i], " rise strobes"}, rises - r0, VEC[i][1]);
      check({TAG[i], " fall strobes"}, falls - f0, VEC[i][0]);
    end

    // R7: enable follows pause pin without a clock edge
    cs_n = 0; hold_n = 1; oe_req = 1; sck = 0;
    settle();
    @(posedge clk); #1;
    hold_n = 0; #1;
    check("R7 float at once", so_oe, 0);
    hold_n = 1; #1;
    check("R7 drive at once", so_oe, 1);
    settle();

    // R9: data sampled with rising strobe
    si = 1; settle();
    r0 = rises;
    sck = 1; settle();
    check("R9 one rise", rises - r0, 1);
    check("R9 si=1 captured", last_si, 1);
    sck = 0; settle();
    si = 0; settle();
    sck = 1; settle();
    check("R9 si=0 captured", last_si, 0);
    sck = 0; settle();

    // R6: clock and data ignored while paused, resume on next rise
    hold_n = 0; settle();
    check("R6 entered pause", paused, 1);
    r0 = rises; f0 = falls;
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1; settle();
      sck = 0; settle();
    end
    check("R6 no rises while paused", rises - r0, 0);
    check("R6 no falls while paused", falls - f0, 0);
    check("R6 still paused", paused, 1);
    hold_n = 1; settle();
    check("R6 released", paused, 0);
    si = 1; settle();
    sck = 1; settle();
    check("R6 resume rise", rises - r0, 1);
    check("R6 resume data", last_si, 1);
    sck = 0; settle();

    // R8: chip select high while pause pin low
    hold_n = 0; settle();
    cs_n = 1; settle();
    check("R8 pause cleared", paused, 0);
    r0 = rises;
    sck = 1; settle();
    check("R8 no strobe deselected", rises - r0, 0);
    sck = 0; settle();

    report();
  end
endmodule